// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block powers up a PCIe root port in a fixed order after a one-cycle start request. It first holds the port quiet: the PHY test power-down is on, link training is off and the reference clock is gated. In that state it drives the endpoint reset line low for a programmable time. It then powers the endpoint and ungates the reference clock. Next it enables four clocks one at a time, each only after the previous one has acknowledged. It waits for the clocks to settle, then enables link training and samples a link-up input at a fixed interval.

The run ends in one of three results. If a link-up sample is seen, the result is success. If a bounded number of samples pass without link-up, the result is link failure, and two PHY debug words are captured at the last sample. If a clock never acknowledges, the result is a clock error; before it is reported, the clocks already enabled are turned off again, newest first. Every delay is given in microseconds and scaled by a cycles-per-microsecond parameter, so a simulation can run with short delays.

Top module: `pcie_rp_bringup`

## Requirements
- R1: After reset the block is idle: test_pd_o=1, ep_rst_n_o=0, and ref_clk_en_o, ep_pwr_en_o, clk_en_o, train_en_o, busy_o, done_o, all result flags and both debug outputs are 0.
- R2: A start accepted while idle or done drives ep_rst_n_o low for exactly RST_US*CYC_PER_US cycles. For that whole time test_pd_o=1, ref_clk_en_o=0 and train_en_o=0.
- R3: ep_pwr_en_o rises in the cycle in which ep_rst_n_o returns high. One cycle later, test_pd_o falls and ref_clk_en_o rises.
- R4: The clocks are enabled one at a time, in the order clk_en_o bit 0 (100 MHz reference), bit 1 (125 MHz reference), bit 2 (LVDS gate), bit 3 (bus clock). Bit 0 rises one cycle after ref_clk_en_o. Each later bit rises in the cycle after the acknowledge of the previous bit is sampled high.
- R5: If the acknowledge for the newest enabled clock is low for ACK_TMO sampled cycles, the enabled clock bits are cleared one per cycle, highest first. The cycle after the last bit is cleared, the block reports done_o=1 with clk_err_o=1.
- R6: train_en_o rises SETTLE_US*CYC_PER_US+1 cycles after the cycle in which the bit 3 acknowledge is sampled high.
- R7: While training is enabled, link_up is sampled only once every POLL_US*CYC_PER_US cycles. A high value on any other cycle has no effect. A high sample leads, one cycle later, to done_o=1 and link_ok_o=1.
- R8: After MAX_POLLS low samples, the debug inputs from the last sampling cycle appear on phy_dbg0_o and phy_dbg1_o. One cycle later the block reports done_o=1 with link_fail_o=1. The debug outputs are cleared when polling starts.
- R9: start has no effect while busy_o=1. A start while done_o=1 clears the result flags and begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a bring-up sequence |
| clk_ack | input | N_CLK | Per-clock enable acknowledge |
| link_up | input | 1 | Link-up indication from the controller |
| phy_dbg0_i | input | DBG_W | PHY debug word 0 |
| phy_dbg1_i | input | DBG_W | PHY debug word 1 |
| test_pd_o | output | 1 | PHY test power-down |
| ref_clk_en_o | output | 1 | Reference clock enable |
| ep_rst_n_o | output | 1 | Endpoint reset, active low |
| ep_pwr_en_o | output | 1 | Endpoint power enable |
| clk_en_o | output | N_CLK | Clock enables, bit 0 first |
| train_en_o | output | 1 | Link-training enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| link_ok_o | output | 1 | Result: link came up |
| link_fail_o | output | 1 | Result: poll limit reached |
| clk_err_o | output | 1 | Result: clock acknowledge missing |
| phy_dbg0_o | output | DBG_W | Captured debug word 0 |
| phy_dbg1_o | output | DBG_W | Captured debug word 1 |

## Verification
The hardest case to reach from the ports is the unwind after the last clocks fail to acknowledge. Several enables must already be high and must then drop one per cycle, highest first. The bench gets there by holding selected acknowledge bits low through a mask, and by releasing one of them late so that one run includes a multi-cycle wait that does succeed. Link-up pulses are placed between poll samples to show that they are ignored. All timing is checked every cycle against a behavioural model of the sequence.

// File: rtl/rpbu_pkg.sv
package rpbu_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_PWR,
        SQ_REFON,
        SQ_CLKS,
        SQ_SETTLE,
        SQ_TRAIN,
        SQ_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_LINK_OK,
        RES_LINK_FAIL,
        RES_CLK_ERR
    } result_e;

    typedef enum logic [1:0] {
        CC_IDLE,
        CC_WAIT,
        CC_UNWIND
    } chain_state_e;

    typedef struct packed {
        logic test_pd;
        logic ep_rst_n;
        logic ep_pwr;
        logic ref_en;
        logic train_en;
        logic busy;
        logic done;
        logic ok;
        logic fail;
        logic cerr;
    } pins_t;

    // Pin levels are a pure function of sequence step and stored result.
    function automatic pins_t decode_pins(seq_state_e s, result_e r);
        pins_t p;
        p          = '0;
        p.test_pd  = (s == SQ_IDLE) || (s == SQ_HOLD) || (s == SQ_PWR);
        p.ep_rst_n = !((s == SQ_IDLE) || (s == SQ_HOLD));
        p.ep_pwr   = p.ep_rst_n;
        p.ref_en   = p.ep_pwr && (s != SQ_PWR);
        p.train_en = (s == SQ_TRAIN) || ((s == SQ_DONE) && (r != RES_CLK_ERR));
        p.busy     = !((s == SQ_IDLE) || (s == SQ_DONE));
        p.done     = (s == SQ_DONE);
        p.ok       = p.done && (r == RES_LINK_OK);
        p.fail     = p.done && (r == RES_LINK_FAIL);
        p.cerr     = p.done && (r == RES_CLK_ERR);
        return p;
    endfunction

endpackage

// File: rtl/rpbu_timer.sv
module rpbu_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + W'(1);
    end

    assign hit = run && (cnt_q == limit - W'(1));

endmodule

// File: rtl/rpbu_clk_chain.sv
module rpbu_clk_chain import rpbu_pkg::*; #(
    parameter int unsigned N_CLK   = 4,
    parameter int unsigned ACK_TMO = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             go,
    input  logic [N_CLK-1:0] ack,
    output logic [N_CLK-1:0] en,
    output logic             ok,
    output logic             err
);
    localparam int unsigned IW  = (N_CLK > 1) ? $clog2(N_CLK) : 1;
    localparam int unsigned TMW = $clog2(ACK_TMO + 1);

    chain_state_e     st_q;
    logic [N_CLK-1:0] en_q;
    logic [IW-1:0]    idx_q;
    logic [TMW-1:0]   t_q;
    logic             ok_q, err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CC_IDLE;
            en_q  <= '0;
            idx_q <= '0;
            t_q   <= '0;
            ok_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ok_q  <= 1'b0;
            err_q <= 1'b0;
            if (clr) begin
                st_q  <= CC_IDLE;
                en_q  <= '0;
                idx_q <= '0;
                t_q   <= '0;
            end else begin
                case (st_q)
                    CC_IDLE: begin
                        if (go) begin
                            st_q    <= CC_WAIT;
                            en_q[0] <= 1'b1;
                            idx_q   <= '0;
                            t_q     <= '0;
                        end
                    end
                    CC_WAIT: begin
                        if (ack[idx_q]) begin
                            t_q <= '0;
                            if (idx_q == IW'(N_CLK - 1)) begin
                                ok_q <= 1'b1;
                                st_q <= CC_IDLE;
                            end else begin
                                idx_q                <= idx_q + IW'(1);
                                en_q[idx_q + IW'(1)] <= 1'b1;
                            end
                        end else if (t_q == TMW'(ACK_TMO - 1)) begin
                            st_q <= CC_UNWIND;
                        end else begin
                            t_q <= t_q + TMW'(1);
                        end
                    end
                    CC_UNWIND: begin
                        en_q[idx_q] <= 1'b0;
                        if (idx_q == '0) begin
                            err_q <= 1'b1;
                            st_q  <= CC_IDLE;
                        end else begin
                            idx_q <= idx_q - IW'(1);
                        end
                    end
                    default: st_q <= CC_IDLE;
                endcase
            end
        end
    end

    assign en  = en_q;
    assign ok  = ok_q;
    assign err = err_q;

    AST_EN_PREFIX: assert property (@(posedge clk) disable iff (rst)
        (en_q & (en_q + N_CLK'(1))) == '0); // R4

    AST_UNWIND_STEP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ($countones(en_q) + 1 >= $countones($past(en_q)))); // R5

endmodule

// File: rtl/rpbu_link_poll.sv
module rpbu_link_poll #(
    parameter int unsigned POLL_CYC  = 100,
    parameter int unsigned MAX_POLLS = 200,
    parameter int unsigned DBG_W     = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             link_up,
    input  logic [DBG_W-1:0] dbg0_i,
    input  logic [DBG_W-1:0] dbg1_i,
    output logic             pass,
    output logic             fail,
    output logic [DBG_W-1:0] dbg0_o,
    output logic [DBG_W-1:0] dbg1_o
);
    localparam int unsigned PW = $clog2(POLL_CYC + 1);
    localparam int unsigned NW = $clog2(MAX_POLLS + 1);

    logic             run_q, pass_q, fail_q;
    logic [PW-1:0]    t_q;
    logic [NW-1:0]    n_q;
    logic [DBG_W-1:0] d0_q, d1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            t_q    <= '0;
            n_q    <= '0;
            d0_q   <= '0;
            d1_q   <= '0;
        end else begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            if (go) begin
                run_q <= 1'b1;
                t_q   <= '0;
                n_q   <= '0;
                d0_q  <= '0;
                d1_q  <= '0;
            end else if (run_q) begin
                if (t_q == PW'(POLL_CYC - 1)) begin
                    t_q <= '0;
                    if (link_up) begin
                        pass_q <= 1'b1;
                        run_q  <= 1'b0;
                    end else if (n_q == NW'(MAX_POLLS - 1)) begin
                        fail_q <= 1'b1;
                        run_q  <= 1'b0;
                        d0_q   <= dbg0_i;
                        d1_q   <= dbg1_i;
                    end else begin
                        n_q <= n_q + NW'(1);
                    end
                end else begin
                    t_q <= t_q + PW'(1);
                end
            end
        end
    end

    assign pass   = pass_q;
    assign fail   = fail_q;
    assign dbg0_o = d0_q;
    assign dbg1_o = d1_q;

    AST_DBG_CLEAR_WHILE_POLL: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (d0_q == '0) && (d1_q == '0)); // R8

    AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (rst)
        (pass_q || fail_q) |=> !run_q && !pass_q && !fail_q); // R7

endmodule

// File: rtl/pcie_rp_bringup.sv
module pcie_rp_bringup import rpbu_pkg::*; #(
    parameter int unsigned CYC_PER_US = 125,
    parameter int unsigned RST_US     = 100000,
    parameter int unsigned SETTLE_US  = 200,
    parameter int unsigned POLL_US    = 100,
    parameter int unsigned MAX_POLLS  = 200,
    parameter int unsigned ACK_TMO    = 64,
    parameter int unsigned N_CLK      = 4,
    parameter int unsigned DBG_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N_CLK-1:0] clk_ack,
    input  logic             link_up,
    input  logic [DBG_W-1:0] phy_dbg0_i,
    input  logic [DBG_W-1:0] phy_dbg1_i,
    output logic             test_pd_o,
    output logic             ref_clk_en_o,
    output logic             ep_rst_n_o,
    output logic             ep_pwr_en_o,
    output logic [N_CLK-1:0] clk_en_o,
    output logic             train_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             link_ok_o,
    output logic             link_fail_o,
    output logic             clk_err_o,
    output logic [DBG_W-1:0] phy_dbg0_o,
    output logic [DBG_W-1:0] phy_dbg1_o
);
    localparam int unsigned RST_CYC    = RST_US * CYC_PER_US;
    localparam int unsigned SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int unsigned POLL_CYC   = POLL_US * CYC_PER_US;
    localparam int unsigned LONGEST    = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
    localparam int unsigned TW         = $clog2(LONGEST + 1);

    seq_state_e st_q, st_d;
    result_e    res_q, res_d;
    pins_t      pins;

    logic          start_acc;
    logic          tmr_run, tmr_hit;
    logic [TW-1:0] tmr_lim;
    logic          chain_ok, chain_err;
    logic          poll_go, poll_pass, poll_fail;

    assign start_acc = start && ((st_q == SQ_IDLE) || (st_q == SQ_DONE));
    assign tmr_run   = (st_q == SQ_HOLD) || (st_q == SQ_SETTLE);
    assign tmr_lim   = (st_q == SQ_HOLD) ? TW'(RST_CYC) : TW'(SETTLE_CYC);
    assign poll_go   = (st_q == SQ_SETTLE) && tmr_hit;

    rpbu_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (tmr_run),
        .limit (tmr_lim),
        .hit   (tmr_hit)
    );

    rpbu_clk_chain #(.N_CLK(N_CLK), .ACK_TMO(ACK_TMO)) u_chain (
        .clk (clk),
        .rst (rst),
        .clr (start_acc),
        .go  (st_q == SQ_REFON),
        .ack (clk_ack),
        .en  (clk_en_o),
        .ok  (chain_ok),
        .err (chain_err)
    );

    rpbu_link_poll #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS), .DBG_W(DBG_W)) u_poll (
        .clk     (clk),
        .rst     (rst),
        .go      (poll_go),
        .link_up (link_up),
        .dbg0_i  (phy_dbg0_i),
        .dbg1_i  (phy_dbg1_i),
        .pass    (poll_pass),
        .fail    (poll_fail),
        .dbg0_o  (phy_dbg0_o),
        .dbg1_o  (phy_dbg1_o)
    );

    always_comb begin
        st_d  = st_q;
        res_d = res_q;
        case (st_q)
            SQ_IDLE, SQ_DONE: begin
                if (start_acc) begin
                    st_d  = SQ_HOLD;
                    res_d = RES_NONE;
                end
            end
            SQ_HOLD:   if (tmr_hit) st_d = SQ_PWR;
            SQ_PWR:    st_d = SQ_REFON;
            SQ_REFON:  st_d = SQ_CLKS;
            SQ_CLKS: begin
                if (chain_ok) begin
                    st_d = SQ_SETTLE;
                end else if (chain_err) begin
                    st_d  = SQ_DONE;
                    res_d = RES_CLK_ERR;
                end
            end
            SQ_SETTLE: if (tmr_hit) st_d = SQ_TRAIN;
            SQ_TRAIN: begin
                if (poll_pass) begin
                    st_d  = SQ_DONE;
                    res_d = RES_LINK_OK;
                end else if (poll_fail) begin
                    st_d  = SQ_DONE;
                    res_d = RES_LINK_FAIL;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            res_q <= RES_NONE;
        end else begin
            st_q  <= st_d;
            res_q <= res_d;
        end
    end

    assign pins         = decode_pins(st_q, res_q);
    assign test_pd_o    = pins.test_pd;
    assign ref_clk_en_o = pins.ref_en;
    assign ep_rst_n_o   = pins.ep_rst_n;
    assign ep_pwr_en_o  = pins.ep_pwr;
    assign train_en_o   = pins.train_en;
    assign busy_o       = pins.busy;
    assign done_o       = pins.done;
    assign link_ok_o    = pins.ok;
    assign link_fail_o  = pins.fail;
    assign clk_err_o    = pins.cerr;

    AST_RST_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ep_rst_n_o |-> test_pd_o && !ref_clk_en_o && !train_en_o); // R2

    AST_CLK_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
        (|clk_en_o) |-> ref_clk_en_o && ep_pwr_en_o); // R4

    AST_TRAIN_ALL_CLKS: assert property (@(posedge clk) disable iff (rst)
        train_en_o |-> (&clk_en_o)); // R6

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones({link_ok_o, link_fail_o, clk_err_o}) == 1)); // R7

    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (st_q != SQ_HOLD)) |=> (st_q != SQ_HOLD)); // R9

endmodule

// File: tb/pcie_rp_bringup_tb_top.sv
module pcie_rp_bringup_tb_top;
    localparam int unsigned CYC_PER_US = 2;
    localparam int unsigned RST_US     = 10;
    localparam int unsigned SETTLE_US  = 5;
    localparam int unsigned POLL_US    = 4;
    localparam int unsigned MAX_POLLS  = 6;
    localparam int unsigned ACK_TMO    = 5;
    localparam int unsigned N_CLK      = 4;
    localparam int unsigned DBG_W      = 32;
    localparam int RST_CYC    = RST_US * CYC_PER_US;
    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int POLL_CYC   = POLL_US * CYC_PER_US;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic link_up = 1'b0;
    logic [N_CLK-1:0] ack_mask = '1;
    logic [DBG_W-1:0] dbg0 = 32'h0000_0001;
    logic [DBG_W-1:0] dbg1 = 32'hA5A5_0000;
    logic [N_CLK-1:0] clk_ack;

    logic test_pd_o, ref_clk_en_o, ep_rst_n_o, ep_pwr_en_o, train_en_o;
    logic busy_o, done_o, link_ok_o, link_fail_o, clk_err_o;
    logic [N_CLK-1:0] clk_en_o;
    logic [DBG_W-1:0] phy_dbg0_o, phy_dbg1_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign clk_ack = clk_en_o & ack_mask;

    always @(negedge clk) begin
        dbg0 <= dbg0 + 32'h1357;
        dbg1 <= dbg1 ^ {dbg0[15:0], dbg0[31:16]};
    end

    pcie_rp_bringup #(
        .CYC_PER_US(CYC_PER_US), .RST_US(RST_US), .SETTLE_US(SETTLE_US),
        .POLL_US(POLL_US), .MAX_POLLS(MAX_POLLS), .ACK_TMO(ACK_TMO),
        .N_CLK(N_CLK), .DBG_W(DBG_W)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .clk_ack(clk_ack), .link_up(link_up),
        .phy_dbg0_i(dbg0), .phy_dbg1_i(dbg1),
        .test_pd_o(test_pd_o), .ref_clk_en_o(ref_clk_en_o), .ep_rst_n_o(ep_rst_n_o),
        .ep_pwr_en_o(ep_pwr_en_o), .clk_en_o(clk_en_o), .train_en_o(train_en_o),
        .busy_o(busy_o), .done_o(done_o), .link_ok_o(link_ok_o),
        .link_fail_o(link_fail_o), .clk_err_o(clk_err_o),
        .phy_dbg0_o(phy_dbg0_o), .phy_dbg1_o(phy_dbg1_o)
    );

    // Expected values from the behavioural model.
    logic e_tpd, e_ref, e_rstn, e_pwr, e_train, e_busy, e_done, e_ok, e_fail, e_cerr;
    logic [N_CLK-1:0] e_clk;
    logic [DBG_W-1:0] e_dbg0, e_dbg1;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    task automatic model_idle();
        e_tpd = 1; e_ref = 0; e_rstn = 0; e_pwr = 0; e_clk = '0; e_train = 0;
        e_busy = 0; e_done = 0; e_ok = 0; e_fail = 0; e_cerr = 0;
        e_dbg0 = '0; e_dbg1 = '0;
    endtask

    task automatic finish_run(input logic ok, input logic fl, input logic ce);
        e_busy = 0; e_done = 1; e_ok = ok; e_fail = fl; e_cerr = ce;
    endtask

    task automatic run_model();
        int  t;
        int  fi;
        int  n;
        bit  failed;
        e_tpd = 1; e_ref = 0; e_rstn = 0; e_pwr = 0; e_clk = '0; e_train = 0;
        e_busy = 1; e_done = 0; e_ok = 0; e_fail = 0; e_cerr = 0;
        repeat (RST_CYC) @(posedge clk);
        e_rstn = 1; e_pwr = 1;
        @(posedge clk);
        e_tpd = 0; e_ref = 1;
        @(posedge clk);
        e_clk[0] = 1;
        failed = 0;
        fi = 0;
        for (int i = 0; i < N_CLK; i++) begin
            t = 0;
            forever begin
                @(posedge clk);
                if (ack_mask[i]) begin
                    if (i < N_CLK - 1) e_clk[i+1] = 1;
                    break;
                end
                if (t == ACK_TMO - 1) begin
                    failed = 1;
                    fi = i;
                    break;
                end
                t++;
            end
            if (failed) break;
        end
        if (failed) begin
            for (int j = fi; j >= 0; j--) begin
                @(posedge clk);
                e_clk[j] = 0;
            end
            @(posedge clk);
            finish_run(0, 0, 1);
            return;
        end
        @(posedge clk);
        repeat (SETTLE_CYC) @(posedge clk);
        e_train = 1; e_dbg0 = '0; e_dbg1 = '0;
        n = 0;
        forever begin
            repeat (POLL_CYC) @(posedge clk);
            if (link_up) begin
                @(posedge clk);
                finish_run(1, 0, 0);
                break;
            end
            if (n == MAX_POLLS - 1) begin
                e_dbg0 = dbg0; e_dbg1 = dbg1;
                @(posedge clk);
                finish_run(0, 1, 0);
                break;
            end
            n++;
        end
    endtask

    initial begin : ref_model
        model_idle();
        forever begin
            @(posedge clk);
            if (rst) model_idle();
            else if (start && !e_busy) run_model();
        end
    end

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 test_pd_o", test_pd_o, e_tpd);
            chk("R2 ep_rst_n_o", ep_rst_n_o, e_rstn);
            chk("R3 ep_pwr_en_o", ep_pwr_en_o, e_pwr);
            chk("R3 ref_clk_en_o", ref_clk_en_o, e_ref);
            chk("R4/R5 clk_en_o", clk_en_o, e_clk);
            chk("R6 train_en_o", train_en_o, e_train);
            chk("R9 busy_o", busy_o, e_busy);
            chk("R7 done_o", done_o, e_done);
            chk("R7 link_ok_o", link_ok_o, e_ok);
            chk("R8 link_fail_o", link_fail_o, e_fail);
            chk("R5 clk_err_o", clk_err_o, e_cerr);
            chk("R8 phy_dbg0_o", phy_dbg0_o, e_dbg0);
            chk("R8 phy_dbg1_o", phy_dbg1_o, e_dbg1);
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    task automatic do_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    initial begin : stim
        int cnt;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: idle state after reset
        chk("R1 idle pins", {test_pd_o, ref_clk_en_o, ep_rst_n_o, ep_pwr_en_o, train_en_o},
            5'b10000);
        chk("R1 idle status", {busy_o, done_o, link_ok_o, link_fail_o, clk_err_o, clk_en_o}, '0);
        chk("R1 idle dbg", {phy_dbg0_o, phy_dbg1_o}, '0);

        // Run A: all acks, stray link pulse, start while busy (R9), link up -> ok (R7)
        ack_mask = '1;
        do_start();
        cnt = 0;
        while (!ep_rst_n_o) begin
            cnt++;
            start = (cnt == 3);
            @(negedge clk);
        end
        start = 0;
        chk("R2 reset low length (R9 restart ignored)", cnt, RST_CYC);
        while (!train_en_o) @(negedge clk);
        link_up = 1;
        @(negedge clk);
        link_up = 0;
        repeat (POLL_CYC + 2) @(negedge clk);
        chk("R7 stray link pulse ignored", done_o, 0);
        link_up = 1;
        wait_done();
        chk("R7 link ok", link_ok_o, 1);
        link_up = 0;

        // Run B: link never up -> fail with captured debug (R8)
        do_start();
        chk("R9 restart clears flags", {done_o, link_ok_o}, 2'b00);
        wait_done();
        chk("R8 link fail", link_fail_o, 1);
        chk("R8 dbg0 captured", phy_dbg0_o, e_dbg0);

        // Run C: bit 2 never acknowledges -> unwind (R5)
        ack_mask = 4'b1011;
        do_start();
        wait_done();
        chk("R5 clk err", clk_err_o, 1);
        chk("R5 clocks off", clk_en_o, 0);

        // Run D: bit 1 acknowledges late, link up at first poll (R4)
        ack_mask = 4'b1101;
        link_up = 1;
        do_start();
        while (!clk_en_o[1]) @(negedge clk);
        chk("R4 order at bit1", clk_en_o, 4'b0011);
        repeat (3) @(negedge clk);
        ack_mask[1] = 1;
        wait_done();
        chk("R4 late ack ok", link_ok_o, 1);
        link_up = 0;

        // Run E: bit 0 never acknowledges (R5)
        ack_mask = 4'b0000;
        do_start();
        wait_done();
        chk("R5 first clock err", clk_err_o, 1);
        chk("R5 train stays off", train_en_o, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule